// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Out-of-Range Policy

This block converts a binary64 floating-point operand into a 32- or 64-bit signed or unsigned integer, delivered in a 64-bit result. A single-precision option first narrows the operand to single precision. A 3-bit mode code picks one of three policies for NaN and out-of-range inputs. The same code also chooses whether rounding is forced toward zero or taken from a 2-bit dynamic rounding input.

Along with the integer, the block reports four conditions. The first is an integer overflow indication, gated by an enable. The other three are an invalid-conversion flag, a signalling-NaN flag and an inexact flag. A separate output marks illegal mode codes. The conversion is combinational, and its result is captured into output registers whenever the input strobe is high. The result therefore appears one cycle after the operand, together with a valid strobe.

Top module: `fp_int_convert`

## Requirements
- R1: `outValid` is high exactly one cycle after a cycle with `inValid` high. Results and flags are captured only on those cycles and hold otherwise. After reset, all outputs are 0.
- R2: Mode codes 110 and 111 are illegal. They give a zero result, raise `illegalMode`, and clear every other flag.
- R3: Rounding is toward zero when mode bit 0 is 1, or when `dynRound` is 01. Otherwise `dynRound` 00 rounds to nearest-even, 10 rounds toward +infinity and 11 rounds toward -infinity.
- R4: Mode codes 000 and 001 saturate. NaN gives the type minimum. A rounded value above the type maximum gives the maximum, and one below the type minimum gives the minimum. The range test uses the rounded value.
- R5: Mode codes 010 and 011 saturate like R4, except that NaN gives 0.
- R6: Mode codes 100 and 101 wrap. NaN, infinity and magnitudes of 2^128 or more give 0. Any other rounded value is reduced modulo 2^width.
- R7: `intType` selects the integer type: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. Signed 32-bit results are sign-extended to 64 bits, and unsigned 32-bit results are zero-extended.
- R8: `overflow` is 1 only when `ovEnable` is 1 and the source is not exactly preserved. That is the case when the source is NaN, when it had a fractional part, or when it was saturated or wrapped.
- R9: `invalidOp` is 1 when the source is NaN or when the rounded value lies outside the range of the integer type. Infinities count as outside the range.
- R10: `snanOp` is 1 when the source is a NaN whose quiet bit (fraction bit 51) is 0.
- R11: `inexact` is 1 when the result is not invalid and rounding discarded a nonzero fraction.
- R12: When `singleSel` is 1, the low 29 fraction bits are dropped before conversion. The sign, exponent and upper 23 fraction bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand present this cycle |
| opnd | input | 64 | Binary64 operand bits |
| cvtMode | input | 3 | Policy and rounding-source code |
| intType | input | 2 | Target integer type |
| dynRound | input | 2 | Dynamic rounding mode |
| singleSel | input | 1 | Narrow the operand to single precision first |
| ovEnable | input | 1 | Enable for the overflow output |
| outValid | output | 1 | Result registers loaded last cycle |
| result | output | 64 | Converted integer |
| overflow | output | 1 | Gated inexact-preservation indication |
| invalidOp | output | 1 | Invalid conversion |
| snanOp | output | 1 | Signalling NaN source |
| inexact | output | 1 | Fraction discarded |
| illegalMode | output | 1 | Mode code 110 or 111 |

## Verification
The bench builds the block with its default binary64 and 64-bit integer parameters. The operand set is chosen so that each type boundary is straddled from both sides: 2^31, 2^32, 2^63, 2^64 and 2^128, together with halfway and near-halfway fractions, infinities, both NaN kinds, a subnormal and a value that narrowing makes exact. Each operand is swept over all eight mode codes, four types, four dynamic rounding modes and both precision choices. This covers every policy and rounding path at every saturation and wrap edge.

// File: rtl/fp_int_convert_pkg.sv
package fp_int_convert_pkg;
  timeunit 1ns; timeprecision 100ps;

  typedef enum logic [1:0] {
    RND_ZERO,
    RND_NEAR,
    RND_UP,
    RND_DOWN
  } rndSel_e;

  typedef enum logic [1:0] {
    POL_SAT_MIN,
    POL_SAT_ZERO,
    POL_WRAP
  } policy_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    illegal;
    logic    narrow;
    logic    isSigned;
    logic    is64;
    logic    ovEn;
    rndSel_e rnd;
    policy_e policy;
  } cvtCtl_t;
endpackage

// File: rtl/fp_int_convert_ctrl.sv
module fp_int_convert_ctrl
  import fp_int_convert_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] cvtMode,
  input  logic [1:0] intType,
  input  logic [1:0] dynRound,
  input  logic       singleSel,
  input  logic       ovEnable,
  output cvtCtl_t    ctl
);
  timeunit 1ns; timeprecision 100ps;

  always_comb begin
    ctl.load     = inValid;
    ctl.illegal  = cvtMode[2] & cvtMode[1];
    ctl.narrow   = singleSel;
    ctl.isSigned = ~intType[0];
    ctl.is64     = intType[1];
    ctl.ovEn     = ovEnable;
    if (cvtMode[2])      ctl.policy = POL_WRAP;
    else if (cvtMode[1]) ctl.policy = POL_SAT_ZERO;
    else                 ctl.policy = POL_SAT_MIN;
    // forced truncate or dynamic 01 -> toward zero
    if (cvtMode[0] || dynRound == 2'b01) ctl.rnd = RND_ZERO;
    else begin
      case (dynRound)
        2'b00:   ctl.rnd = RND_NEAR;
        2'b10:   ctl.rnd = RND_UP;
        default: ctl.rnd = RND_DOWN;
      endcase
    end
  end
endmodule

// File: rtl/fp_int_convert_dp.sv
module fp_int_convert_dp
  import fp_int_convert_pkg::*;
#(
  parameter int EXP_W       = 11,
  parameter int FRAC_W      = 52,
  parameter int NARROW_FRAC = 23,
  parameter int INT_W       = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cvtCtl_t                 ctl,
  input  logic [EXP_W+FRAC_W:0]   opnd,
  output logic                    outValid,
  output logic [INT_W-1:0]        result,
  output logic                    overflow,
  output logic                    invalidOp,
  output logic                    snanOp,
  output logic                    inexact,
  output logic                    illegalMode
);
  timeunit 1ns; timeprecision 100ps;

  localparam int OP_W  = 1 + EXP_W + FRAC_W;
  localparam int MW    = FRAC_W + 1;
  localparam int ACC_W = 2 * INT_W;
  localparam int MAG_W = ACC_W + 1;
  localparam int HALF  = INT_W / 2;
  localparam int SW    = $clog2(INT_W) + 1;
  localparam int RSW   = $clog2(MW) + 1;
  localparam int LSW   = $clog2(ACC_W);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic [FRAC_W-1:0] KEEP =
    {{NARROW_FRAC{1'b1}}, {(FRAC_W - NARROW_FRAC){1'b0}}};

  logic              sgn, isNan, isInf;
  logic [EXP_W-1:0]  expF;
  logic [FRAC_W-1:0] frac;
  logic [MW-1:0]     mant;
  int                eI;

  assign sgn   = opnd[OP_W-1];
  assign expF  = opnd[OP_W-2 -: EXP_W];
  assign frac  = ctl.narrow ? (opnd[FRAC_W-1:0] & KEEP) : opnd[FRAC_W-1:0];
  assign isNan = (&expF) && (|frac);
  assign isInf = (&expF) && !(|frac);
  assign mant  = {|expF, frac};
  assign eI    = ((expF == '0) ? 1 : int'(expF)) - BIAS;

  // split into integer part, guard bit and sticky
  logic [ACC_W-1:0] intPart;
  logic             guardB, stickyB, tooBig;
  logic [RSW-1:0]   rs;
  logic [LSW-1:0]   shAmt;

  always_comb begin
    intPart = '0;
    guardB  = 1'b0;
    stickyB = 1'b0;
    tooBig  = 1'b0;
    rs      = '0;
    shAmt   = '0;
    if (isInf || isNan || eI >= ACC_W) begin
      tooBig = 1'b1;
    end else if (eI >= FRAC_W) begin
      shAmt   = LSW'(eI - FRAC_W);
      intPart = ACC_W'(mant) << shAmt;
    end else if (eI >= -1) begin
      rs      = RSW'(FRAC_W - eI);
      intPart = ACC_W'(mant >> rs);
      guardB  = mant[6'(rs - RSW'(1))];
      stickyB = |(mant & ((MW'(1) << (rs - RSW'(1))) - MW'(1)));
    end else begin
      stickyB = |mant;
    end
  end

  logic fracLost, incr;
  logic [MAG_W-1:0] magR;

  assign fracLost = guardB | stickyB;

  always_comb begin
    case (ctl.rnd)
      RND_NEAR: incr = guardB & (stickyB | intPart[0]);
      RND_UP:   incr = ~sgn & fracLost;
      RND_DOWN: incr = sgn & fracLost;
      default:  incr = 1'b0;
    endcase
  end

  assign magR = {1'b0, intPart} + MAG_W'(incr);

  // range limits of the selected type, compared on the rounded value
  logic [SW-1:0]    wBits;
  logic [MAG_W-1:0] posLim, negLim;
  logic             above, below;
  logic [INT_W-1:0] satMax, satMin, magLow, rawVal, pick, extVal;

  assign wBits  = ctl.is64 ? SW'(INT_W) : SW'(HALF);
  assign posLim = (MAG_W'(1) << (wBits - SW'(ctl.isSigned))) - MAG_W'(1);
  assign negLim = ctl.isSigned ? (MAG_W'(1) << (wBits - SW'(1))) : '0;
  assign above  = ~isNan & ~sgn & (tooBig | (magR > posLim));
  assign below  = ~isNan & sgn & (tooBig | (magR > negLim));
  assign satMax = posLim[INT_W-1:0];
  assign satMin = ~negLim[INT_W-1:0] + INT_W'(1);
  assign magLow = magR[INT_W-1:0];
  assign rawVal = sgn ? (~magLow + INT_W'(1)) : magLow;

  always_comb begin
    case (ctl.policy)
      POL_SAT_MIN:  pick = isNan ? satMin : above ? satMax : below ? satMin : rawVal;
      POL_SAT_ZERO: pick = isNan ? '0     : above ? satMax : below ? satMin : rawVal;
      default:      pick = (isNan | tooBig) ? '0 : rawVal;
    endcase
    if (ctl.is64)         extVal = pick;
    else if (ctl.isSigned) extVal = {{HALF{pick[HALF-1]}}, pick[HALF-1:0]};
    else                   extVal = {{HALF{1'b0}}, pick[HALF-1:0]};
  end

  logic invNext;
  assign invNext = isNan | above | below;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      result      <= '0;
      overflow    <= 1'b0;
      invalidOp   <= 1'b0;
      snanOp      <= 1'b0;
      inexact     <= 1'b0;
      illegalMode <= 1'b0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) begin
        if (ctl.illegal) begin
          result      <= '0;
          overflow    <= 1'b0;
          invalidOp   <= 1'b0;
          snanOp      <= 1'b0;
          inexact     <= 1'b0;
          illegalMode <= 1'b1;
        end else begin
          result      <= extVal;
          overflow    <= ctl.ovEn & (invNext | fracLost);
          invalidOp   <= invNext;
          snanOp      <= isNan & ~frac[FRAC_W-1];
          inexact     <= ~invNext & fracLost;
          illegalMode <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fp_int_convert.sv
module fp_int_convert
  import fp_int_convert_pkg::*;
#(
  parameter int EXP_W       = 11,
  parameter int FRAC_W      = 52,
  parameter int NARROW_FRAC = 23,
  parameter int INT_W       = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opnd,
  input  logic [2:0]            cvtMode,
  input  logic [1:0]            intType,
  input  logic [1:0]            dynRound,
  input  logic                  singleSel,
  input  logic                  ovEnable,
  output logic                  outValid,
  output logic [INT_W-1:0]      result,
  output logic                  overflow,
  output logic                  invalidOp,
  output logic                  snanOp,
  output logic                  inexact,
  output logic                  illegalMode
);
  timeunit 1ns; timeprecision 100ps;

  cvtCtl_t ctl;

  fp_int_convert_ctrl u_ctrl (
    .inValid  (inValid),
    .cvtMode  (cvtMode),
    .intType  (intType),
    .dynRound (dynRound),
    .singleSel(singleSel),
    .ovEnable (ovEnable),
    .ctl      (ctl)
  );

  fp_int_convert_dp #(
    .EXP_W      (EXP_W),
    .FRAC_W     (FRAC_W),
    .NARROW_FRAC(NARROW_FRAC),
    .INT_W      (INT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .opnd       (opnd),
    .outValid   (outValid),
    .result     (result),
    .overflow   (overflow),
    .invalidOp  (invalidOp),
    .snanOp     (snanOp),
    .inexact    (inexact),
    .illegalMode(illegalMode)
  );
endmodule

// File: rtl/fp_int_convert_checker.sv
module fp_int_convert_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [63:0] opnd,
  input logic [2:0]  cvtMode,
  input logic [1:0]  intType,
  input logic        singleSel,
  input logic        ovEnable,
  input logic        outValid,
  input logic [63:0] result,
  input logic        overflow,
  input logic        invalidOp,
  input logic        snanOp,
  input logic        inexact,
  input logic        illegalMode
);
  timeunit 1ns; timeprecision 100ps;

  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (outValid == $past(inValid)));

  assert_illegal_clean_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && illegalMode) |->
      (result == 64'd0 && !overflow && !invalidOp && !snanOp && !inexact));

  assert_nan_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && cvtMode[2:1] == 2'b01 && !singleSel
                    && (&opnd[62:52]) && (|opnd[51:0]))) |-> (result == 64'd0));

  assert_nan_invalid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && cvtMode[2:1] != 2'b11 && !singleSel
                    && (&opnd[62:52]) && (|opnd[51:0]))) |-> invalidOp);

  assert_uext_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && intType == 2'b01)) |-> (result[63:32] == 32'd0));

  assert_sext_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && intType == 2'b00)) |->
      (result[63:32] == {32{result[31]}}));

  assert_ov_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inValid && !ovEnable)) |-> !overflow);

  assert_snan_invalid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && snanOp) |-> invalidOp);
endmodule

bind fp_int_convert fp_int_convert_checker u_chk (.*);

// File: tb/fp_int_convert_test.sv
module fp_int_convert_test;
  timeunit 1ns; timeprecision 100ps;

  localparam int NOP = 30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opnd = '0;
  logic [2:0]  cvtMode = '0;
  logic [1:0]  intType = '0;
  logic [1:0]  dynRound = '0;
  logic        singleSel = 1'b0;
  logic        ovEnable = 1'b0;
  logic        outValid, overflow, invalidOp, snanOp, inexact, illegalMode;
  logic [63:0] result;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;
  logic [63:0] ops [NOP];

  always #2.5 clk = ~clk;

  fp_int_convert uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opnd(opnd),
    .cvtMode(cvtMode), .intType(intType), .dynRound(dynRound),
    .singleSel(singleSel), .ovEnable(ovEnable), .outValid(outValid),
    .result(result), .overflow(overflow), .invalidOp(invalidOp),
    .snanOp(snanOp), .inexact(inexact), .illegalMode(illegalMode)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] toBits(input real m);
    if (m >= 2.0 ** 63) return {1'b1, 63'(longint'(m - 2.0 ** 63))};
    return 64'(longint'(m));
  endfunction

  // reference: low 64 bits of an integral real, two's complement
  function automatic logic [63:0] modBits(input real rr);
    real a;
    logic [63:0] b;
    a = (rr < 0.0) ? -rr : rr;
    if (a >= 2.0 ** 64) a = a - $floor(a / 2.0 ** 64) * 2.0 ** 64;
    b = toBits(a);
    return (rr < 0.0) ? (~b + 64'd1) : b;
  endfunction

  task automatic model(input logic [63:0] bits, input int md, input int it,
                       input int dy, input int sg, input logic oe,
                       output logic [63:0] er, output logic [4:0] ef);
    logic [63:0] b, satMax, satMin, v;
    logic nan, inf, fr, above, below, sgnT, wide, inv;
    real r, rr, f, hiW;
    b    = (sg != 0) ? (bits & 64'hFFFF_FFFF_E000_0000) : bits;  // R12
    nan  = (&b[62:52]) && (|b[51:0]);
    inf  = (&b[62:52]) && !(|b[51:0]);
    if (md >= 6) begin
      er = '0; ef = 5'b10000; return;
    end
    sgnT = (it % 2) == 0;
    wide = it >= 2;
    hiW  = wide ? 2.0 ** 64 : 2.0 ** 32;
    rr = 0.0; fr = 1'b0;
    if (!nan) begin
      r = $bitstoreal(b);
      if ((md % 2) == 1 || dy == 1) rr = (r < 0.0) ? $ceil(r) : $floor(r);
      else if (dy == 2) rr = $ceil(r);
      else if (dy == 3) rr = $floor(r);
      else begin
        f  = $floor(r);
        rr = f;
        if (r - f > 0.5) rr = f + 1.0;
        else if (r - f == 0.5 && $floor(f / 2.0) * 2.0 != f) rr = f + 1.0;
      end
      fr = (rr != r);
    end
    above = !nan && (sgnT ? (rr >= hiW / 2.0) : (rr >= hiW));
    below = !nan && (sgnT ? (rr < -hiW / 2.0) : (rr < 0.0));
    satMax = sgnT ? (wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF)
                  : (wide ? '1 : 64'hFFFF_FFFF);
    satMin = sgnT ? (wide ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000) : '0;
    if (nan || inf || rr >= 2.0 ** 128 || rr <= -(2.0 ** 128)) v = '0;
    else v = modBits(rr);
    if (!wide) v = sgnT ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
    case (md / 2)
      0: er = nan ? satMin : above ? satMax : below ? satMin : v;
      1: er = nan ? '0 : above ? satMax : below ? satMin : v;
      default: er = (nan || inf) ? '0 : v;
    endcase
    inv = nan | above | below;
    ef = {1'b0, inv, nan & !b[51], !inv & fr, oe & (inv | fr)};
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [63:0] er, lastRes;
    logic [4:0]  ef;
    string       tag;
    int          vec;
    ops[0]  = $realtobits(0.0);
    ops[1]  = 64'h8000_0000_0000_0000;
    ops[2]  = $realtobits(0.5);
    ops[3]  = $realtobits(-0.5);
    ops[4]  = $realtobits(1.5);
    ops[5]  = $realtobits(2.5);
    ops[6]  = $realtobits(-2.5);
    ops[7]  = $realtobits(-7.3);
    ops[8]  = $realtobits(123456789.75);
    ops[9]  = $realtobits(2147483647.4);
    ops[10] = $realtobits(2147483647.5);
    ops[11] = $realtobits(-2147483648.0);
    ops[12] = $realtobits(-2147483648.5);
    ops[13] = $realtobits(4294967295.5);
    ops[14] = $realtobits(4294967296.0);
    ops[15] = $realtobits(2.0 ** 63 - 1024.0);
    ops[16] = $realtobits(2.0 ** 63);
    ops[17] = $realtobits(-(2.0 ** 63));
    ops[18] = $realtobits(3.0e19);
    ops[19] = $realtobits(2.0 ** 64);
    ops[20] = $realtobits(-1.0e30);
    ops[21] = $realtobits(1.0e40);
    ops[22] = 64'h7FF0_0000_0000_0000;
    ops[23] = 64'hFFF0_0000_0000_0000;
    ops[24] = 64'h7FF8_0000_0000_0000;
    ops[25] = 64'h7FF4_0000_0000_0000;
    ops[26] = 64'hFFF8_0000_0000_0001;
    ops[27] = 64'h0000_0000_0000_0001;
    ops[28] = 64'h3FF0_0000_0000_1000;
    ops[29] = $realtobits(-1.0e10);

    repeat (3) @(negedge clk);
    check("R1 reset outValid", 64'(outValid), 64'd0);
    check("R1 reset result", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 64'(outValid), 64'd0);

    vec = 0;
    for (int op = 0; op < NOP; op++)
      for (int md = 0; md < 8; md++)
        for (int it = 0; it < 4; it++)
          for (int dy = 0; dy < 4; dy++)
            for (int sg = 0; sg < 2; sg++) begin
              inValid   = 1'b1;
              opnd      = ops[op];
              cvtMode   = 3'(md);
              intType   = 2'(it);
              dynRound  = 2'(dy);
              singleSel = sg[0];
              ovEnable  = vec[0];
              vec++;
              @(negedge clk);
              model(ops[op], md, it, dy, sg, vec[0] ^ 1'b1, er, ef);
              // ovEnable was the pre-increment bit; vec[0]^1 recovers it
              if (md >= 6) tag = "R2";
              else if (md < 2) tag = "R4";
              else if (md < 4) tag = "R5";
              else tag = "R6";
              tag = $sformatf("%s/R3/R7%s op=%0d mode=%0d type=%0d rnd=%0d",
                              tag, (sg != 0) ? "/R12" : "", op, md, it, dy);
              check({"R1 valid ", tag}, 64'(outValid), 64'd1);
              check({"result ", tag}, result, er);
              check({"flags R2/R8/R9/R10/R11 ", tag},
                    64'({illegalMode, invalidOp, snanOp, inexact, overflow}), 64'(ef));
            end

    // R1: no capture while inValid is low
    lastRes   = result;
    inValid   = 1'b0;
    opnd      = $realtobits(-99.0);
    cvtMode   = 3'd0;
    intType   = 2'd2;
    singleSel = 1'b0;
    @(negedge clk);
    check("R1 drop outValid", 64'(outValid), 64'd0);
    check("R1 hold result", result, lastRes);
    @(negedge clk);
    check("R1 hold result again", result, lastRes);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule